// File: doc/BRIEF.md
# Page-Buffered Nonvolatile Byte Store

This block is a synchronous model of a byte-wide nonvolatile memory with a static-RAM style bus. The bus has an active-low chip select, an active-low read enable, an active-low write enable, an address and separate 8-bit input and output data. A read returns the stored byte. A write does not reach the array at once. Bytes that share a 64-byte page are gathered in a page buffer. When no further write strobe arrives within a load window, an internal timer commits the gathered bytes to the array.

While a commit runs, reads return status instead of data. Bit 7 is the complement of bit 7 of the last loaded byte, and bit 6 flips on each new read strobe. An optional lock stops stray writes. A fixed three-step command sequence turns the lock on. Once the lock is on, every later page write must be preceded by that same sequence.

The array is `1 << ADDR_W` bytes. The default is small enough to elaborate quickly. Setting `ADDR_W` to 15 gives the full 32,768-byte array. The load window and the commit time are parameters counted in clock cycles.

Top module: `eep_page_writer`

## Requirements
- R1: After reset the block is idle and unlocked, and `dout_oe` is 0 with `dout` at 0x00.
- R2: While `ce_n`=0, `oe_n`=0 and `we_n`=1, `dout_oe` is 1 from the following clock edge and `dout` carries the stored byte at `addr`. Otherwise `dout_oe` is 0.
- R3: A write strobe is a cycle in which `ce_n`=0, `we_n`=0 and `oe_n`=1 after a cycle in which that did not hold. Bytes loaded by write strobes reach the array only once the commit runs. Until then a read of those addresses returns the old contents.
- R4: The first accepted byte fixes the page, which is `addr[ADDR_W-1:6]`. For every byte of the same load, only `addr[5:0]` chooses the position in that page, and the upper bits of later bytes are ignored.
- R5: Each write strobe during the load phase restarts the window. The commit starts `LOAD_WIN` cycles after the last strobe.
- R6: During the commit, `dout[7]` reads as the inverse of bit 7 of the last loaded byte. After the commit it reads the true stored bit.
- R7: During the commit, `dout[6]` takes a different value on each successive read strobe. Outside a commit it does not change between reads.
- R8: Write strobes that arrive during the commit are ignored and do not change the array.
- R9: Writing 0xAA to `CMD_A0`, then 0x55 to `CMD_A1`, then 0xA0 to `CMD_A2` (defaults 0x555, 0x2AA, 0x555) turns the lock on. It also allows the page write that follows.
- R10: While the lock is on, a page write without the preceding sequence is discarded.
- R11: A write that does not match the expected command step returns the sequencer to its first step. While the lock is on, that write is discarded.
- R12: A write that matches the expected command step is taken by the sequencer and is never stored in the array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Read enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or commit status |
| dout_oe | output | 1 | High when `dout` is being driven |

## Verification
Page loads are tried with three patterns. The first scatters bytes over page offsets and gives one byte a foreign upper address, which separates the in-page offset from the full address. The second spaces two strobes just inside the window, which shows whether the window restarts or expires on a fixed schedule. The third reads an address during its own load, which separates buffered bytes from committed bytes. Status reads taken in the middle of a commit are compared with reads taken after it, to separate polled status from data. For the lock, the bench runs a full command sequence, a bare write and a sequence broken after its first step, and each outcome shows in what the array later holds.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOAD   = 2'd1,
    ST_COMMIT = 2'd2
  } eep_state_e;
endpackage

// File: rtl/eep_array.sv
module eep_array #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          busy,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

  // R3: the array only changes while the commit timer is running
  p_write_in_commit_r3: assert property (@(posedge clk) disable iff (rst)
    we |-> busy);
endmodule

// File: rtl/eep_guard.sv
module eep_guard #(
  parameter int              ADDR_W = 11,
  parameter logic [ADDR_W-1:0] CMD_A0 = 'h555,
  parameter logic [ADDR_W-1:0] CMD_A1 = 'h2AA,
  parameter logic [ADDR_W-1:0] CMD_A2 = 'h555,
  parameter logic [7:0]      CMD_D0 = 8'hAA,
  parameter logic [7:0]      CMD_D1 = 8'h55,
  parameter logic [7:0]      CMD_D2 = 8'hA0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data,
  input  logic              disarm,
  output logic              consume,
  output logic              allow,
  output logic              locked
);
  logic [1:0] step;
  logic       armed;
  logic       hit;

  always_comb begin
    case (step)
      2'd0:    hit = (addr == CMD_A0) && (data == CMD_D0);
      2'd1:    hit = (addr == CMD_A1) && (data == CMD_D1);
      2'd2:    hit = (addr == CMD_A2) && (data == CMD_D2);
      default: hit = 1'b0;
    endcase
  end

  assign consume = strobe && hit;
  assign allow   = strobe && !hit && (!locked || armed);

  always_ff @(posedge clk) begin
    if (rst) begin
      step   <= 2'd0;
      armed  <= 1'b0;
      locked <= 1'b0;
    end else begin
      if (strobe) begin
        if (hit && step == 2'd2) begin
          step   <= 2'd0;
          locked <= 1'b1;
          armed  <= 1'b1;
        end else if (hit) begin
          step <= step + 2'd1;
        end else begin
          step <= 2'd0;
        end
      end
      if (disarm) armed <= 1'b0;
    end
  end

  // R9: a write permit only exists once the lock is engaged
  p_arm_needs_lock_r9: assert property (@(posedge clk) disable iff (rst)
    armed |-> locked);
  // R11: any non-matching strobe sends the sequencer back to its first step
  p_mismatch_idle_r11: assert property (@(posedge clk) disable iff (rst)
    (strobe && !hit) |=> (step == 2'd0));
endmodule

// File: rtl/eep_page_writer.sv
module eep_page_writer
  import eep_pkg::*;
#(
  parameter int              ADDR_W     = 11,
  parameter int              PAGE_W     = 6,
  parameter int              LOAD_WIN   = 7500,
  parameter int              COMMIT_CYC = 500000,
  parameter logic [ADDR_W-1:0] CMD_A0   = 'h555,
  parameter logic [ADDR_W-1:0] CMD_A1   = 'h2AA,
  parameter logic [ADDR_W-1:0] CMD_A2   = 'h555,
  parameter logic [7:0]      CMD_D0     = 8'hAA,
  parameter logic [7:0]      CMD_D1     = 8'h55,
  parameter logic [7:0]      CMD_D2     = 8'hA0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_oe
);
  localparam int PAGE_N = 1 << PAGE_W;
  localparam int HI_W   = ADDR_W - PAGE_W;
  localparam int LW_W   = $clog2(LOAD_WIN + 1);
  localparam int CM_W   = $clog2(COMMIT_CYC + 1);

  eep_state_e        st;
  logic [HI_W-1:0]   pg;
  logic [7:0]        pbuf [PAGE_N];
  logic [PAGE_N-1:0] pval;
  logic [7:0]        last_b;
  logic [LW_W-1:0]   lw_cnt;
  logic [CM_W-1:0]   cm_cnt;
  logic              wr_q, rd_q, tog;
  logic              oe_q, sel_q;
  logic [7:0]        stat_q, arr_q;

  logic wr_act, rd_act, ws, rs, busy;
  logic consume, allow, locked;
  logic load_in, commit_start, cm_we;
  logic [PAGE_W-1:0] off, cm_idx;

  assign wr_act = !ce_n && !we_n && oe_n;
  assign rd_act = !ce_n && !oe_n && we_n;
  assign ws     = wr_act && !wr_q;
  assign rs     = rd_act && !rd_q;
  assign busy   = (st == ST_COMMIT);
  assign off    = addr[PAGE_W-1:0];
  assign cm_idx = cm_cnt[PAGE_W-1:0];

  assign load_in      = ((st == ST_IDLE) && allow) || ((st == ST_LOAD) && ws);
  assign commit_start = (st == ST_LOAD) && !ws && (lw_cnt == LW_W'(LOAD_WIN - 1));
  assign cm_we        = busy && (cm_cnt < CM_W'(PAGE_N)) && pval[cm_idx];

  eep_guard #(
    .ADDR_W(ADDR_W), .CMD_A0(CMD_A0), .CMD_A1(CMD_A1), .CMD_A2(CMD_A2),
    .CMD_D0(CMD_D0), .CMD_D1(CMD_D1), .CMD_D2(CMD_D2)
  ) u_guard (
    .clk(clk), .rst(rst), .strobe(ws && st == ST_IDLE), .addr(addr), .data(din),
    .disarm(commit_start), .consume(consume), .allow(allow), .locked(locked)
  );

  eep_array #(.AW(ADDR_W), .DW(8)) u_array (
    .clk(clk), .rst(rst), .busy(busy), .we(cm_we), .waddr({pg, cm_idx}),
    .wdata(pbuf[cm_idx]), .raddr(addr), .rdata(arr_q)
  );

  // page buffer: plain storage, validity held in pval
  always_ff @(posedge clk) begin
    if (load_in) pbuf[off] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      pg     <= '0;
      pval   <= '0;
      last_b <= 8'h00;
      lw_cnt <= '0;
      cm_cnt <= '0;
    end else begin
      case (st)
        ST_IDLE: if (allow) begin
          st     <= ST_LOAD;
          pg     <= addr[ADDR_W-1:PAGE_W];
          pval   <= PAGE_N'(1) << off;
          last_b <= din;
          lw_cnt <= '0;
        end
        ST_LOAD: begin
          if (ws) begin
            pval[off] <= 1'b1;
            last_b    <= din;
            lw_cnt    <= '0;
          end else if (commit_start) begin
            st     <= ST_COMMIT;
            cm_cnt <= '0;
          end else begin
            lw_cnt <= lw_cnt + 1'b1;
          end
        end
        ST_COMMIT: begin
          if (cm_cnt == CM_W'(COMMIT_CYC - 1)) begin
            st   <= ST_IDLE;
            pval <= '0;
          end else begin
            cm_cnt <= cm_cnt + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // read side and status
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q   <= 1'b0;
      rd_q   <= 1'b0;
      tog    <= 1'b0;
      oe_q   <= 1'b0;
      sel_q  <= 1'b0;
      stat_q <= 8'h00;
    end else begin
      wr_q <= wr_act;
      rd_q <= rd_act;
      oe_q <= rd_act;
      if (rs && busy) tog <= !tog;
      if (rd_act) begin
        sel_q  <= busy;
        stat_q <= {!last_b[7], tog ^ (rs && busy), 6'b000000};
      end
    end
  end

  assign dout_oe = oe_q;
  assign dout    = oe_q ? (sel_q ? stat_q : arr_q) : 8'h00;

  // R5: a strobe during loading keeps the block loading with a fresh window
  p_window_restart_r5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LOAD && ws) |=> (st == ST_LOAD && lw_cnt == '0));
  // R6: a status read shows the inverse of the last loaded bit 7
  p_poll_inverted_r6: assert property (@(posedge clk) disable iff (rst)
    (dout_oe && sel_q) |-> (dout[7] == !last_b[7]));
  // R7: the toggle bit is frozen outside a commit
  p_toggle_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    (st != ST_COMMIT) |=> $stable(tog));
  // R8: strobes during the commit leave the loaded state alone
  p_commit_ignores_r8: assert property (@(posedge clk) disable iff (rst)
    (st == ST_COMMIT && ws) |=> $stable(last_b));
  // R1/R2: the output is only driven after a read access
  p_drive_after_read_r2: assert property (@(posedge clk) disable iff (rst)
    dout_oe |-> $past(rd_act));
endmodule

// File: tb/eep_page_writer_bench.sv
module eep_page_writer_bench;
  localparam int AW  = 11;
  localparam int LW  = 20;
  localparam int CMC = 100;
  localparam int FULL = LW + CMC + 8;

  typedef struct {
    logic [7:0] exp;
    logic [7:0] mask;
    string      tag;
  } item_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0]    din = 8'h00;
  logic [7:0]    dout;
  logic          dout_oe;

  int checks = 0;
  int errors = 0;
  item_t sbq [$];
  logic [7:0] last_seen = 8'h00;
  logic       oe_prev = 1'b0;

  always #5 clk = ~clk;

  eep_page_writer #(.ADDR_W(AW), .PAGE_W(6), .LOAD_WIN(LW), .COMMIT_CYC(CMC)) u_eep_page_writer (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe)
  );

  // monitor: pops one expected item per read, on the first driven cycle
  always @(negedge clk) begin
    if (dout_oe && !oe_prev) begin
      last_seen = dout;
      if (sbq.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: unexpected read data %02h (expected none)", dout);
      end else begin
        item_t it;
        it = sbq.pop_front();
        checks++;
        if ((dout & it.mask) != (it.exp & it.mask)) begin
          errors++;
          $display("FAIL %s: got %02h expected %02h (mask %02h)", it.tag, dout, it.exp, it.mask);
        end
      end
    end
    oe_prev = dout_oe;
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk);
    ce_n = 1'b0; we_n = 1'b0; addr = a; din = d;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic rd(logic [AW-1:0] a, logic [7:0] e, logic [7:0] m, string tag);
    item_t it;
    it.exp = e; it.mask = m; it.tag = tag;
    sbq.push_back(it);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0; addr = a;
    @(negedge clk);
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic chk(logic [7:0] got, logic [7:0] exp, string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic unlock_seq();
    wr(11'h555, 8'hAA);
    wr(11'h2AA, 8'h55);
    wr(11'h555, 8'hA0);
  endtask

  initial begin
    logic t1;
    tick(4);
    rst = 1'b0;
    tick(2);
    // R1: idle, undriven after reset
    chk({7'd0, dout_oe}, 8'h00, "R1 dout_oe");
    chk(dout, 8'h00, "R1 dout");

    // R4/R3: scattered offsets, one byte with a foreign upper address
    wr(11'h080, 8'h3C);
    wr(11'h0C1, 8'h5A);
    wr(11'h085, 8'hC7);
    tick(FULL);
    rd(11'h080, 8'h3C, 8'hFF, "R3 offset0");
    rd(11'h081, 8'h5A, 8'hFF, "R4 page fixed by first byte");
    rd(11'h085, 8'hC7, 8'hFF, "R2 read data");

    // R3: read during own load returns old contents, later the new ones
    wr(11'h080, 8'h99);
    rd(11'h080, 8'h3C, 8'hFF, "R3 old data during load");
    tick(FULL);
    rd(11'h080, 8'h99, 8'hFF, "R3 committed data");

    // R5: second strobe just inside the window restarts it
    wr(11'h100, 8'h11);
    tick(LW - 4);
    wr(11'h101, 8'h22);
    tick(LW + 5);
    // R6: in commit, bit 7 inverted relative to last byte (0x22 -> bit7 = 1)
    rd(11'h101, 8'h80, 8'h80, "R6 polling inverted");
    t1 = last_seen[6];
    rd(11'h101, 8'h80, 8'h80, "R6 polling inverted again");
    chk({7'd0, last_seen[6]}, {7'd0, !t1}, "R7 toggle flips");
    // R8: write during commit is ignored
    wr(11'h080, 8'hFF);
    tick(CMC);
    rd(11'h100, 8'h11, 8'hFF, "R5 first byte");
    rd(11'h101, 8'h22, 8'hFF, "R5 second byte kept in same load");
    rd(11'h080, 8'h99, 8'hFF, "R8 write during commit ignored");
    rd(11'h101, 8'h22, 8'hFF, "R6 true data after commit");
    t1 = last_seen[6];
    rd(11'h101, 8'h22, 8'hFF, "R7 stable after commit");
    chk({7'd0, last_seen[6]}, {7'd0, t1}, "R7 toggle stopped");

    // R12/R9: prefill command address, then lock and write
    wr(11'h555, 8'h11);
    tick(FULL);
    rd(11'h555, 8'h11, 8'hFF, "R12 prefill");
    unlock_seq();
    wr(11'h140, 8'h42);
    tick(FULL);
    rd(11'h140, 8'h42, 8'hFF, "R9 write after sequence");
    rd(11'h555, 8'h11, 8'hFF, "R12 command bytes not stored");

    // R10: bare write while locked
    wr(11'h140, 8'h77);
    tick(FULL);
    rd(11'h140, 8'h42, 8'hFF, "R10 bare write discarded");

    // R11: broken sequence, then a full one
    wr(11'h555, 8'hAA);
    wr(11'h140, 8'h88);
    tick(FULL);
    rd(11'h140, 8'h42, 8'hFF, "R11 mismatch discarded");
    unlock_seq();
    wr(11'h141, 8'h66);
    tick(FULL);
    rd(11'h141, 8'h66, 8'hFF, "R11 sequencer back at first step");
    rd(11'h140, 8'h42, 8'hFF, "R11 page untouched");

    tick(3);
    chk(8'(sbq.size()), 8'h00, "R2 all reads observed");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung (got timeout, expected completion)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule